// File: doc/BRIEF.md
# NIC interrupt status aggregator

This block holds the interrupt status of an Ethernet controller's DMA engines. The transmit and receive processes, the timers, the link monitor and the bus interface each raise one-cycle event pulses. The block latches every pulse into its own sticky status bit. The status bits are then gathered into two summary bits. The normal summary covers routine completions. The abnormal summary covers stops, underruns, timer expiry and bus faults. A single interrupt line is driven through a per-bit enable mask.

Software reads the whole status word and clears individual bits by writing ones to them. The word also carries the 3-bit type of the most recent bus error. A separate output gives a registered copy of the receive process state code. The DMA engines, the descriptor logic, the timers and the bus interface are outside this block.

Top module: `nic_irq_status`

## Requirements
- R1: During and after a synchronous active-high reset, every bit of `status_word`, `irq` and `rx_state_code` is 0.
- R2: A pulse on `evt_pulse[i]`, for i in {0,1,2,3,5,...,14}, sets `status_word[i]` on the next clock edge. The positions are: tx done 0, tx stopped 1, tx no buffer 2, tx jabber 3, tx underrun 5, rx done 6, rx no buffer 7, rx stopped 8, rx watchdog 9, tx early 10, timer 11, link change 12, bus error 13, early rx 14. Each bit stays set until it is cleared.
- R3: A write (`wr_en`=1) clears every live status bit whose `wr_data` bit is 1. Bits whose `wr_data` bit is 0 are unchanged.
- R4: If an event and a clear for the same bit arrive in the same cycle, the event wins and the bit is 1 afterwards.
- R5: A pulse on `evt_pulse[0]` (tx done) clears status bit 10 (tx early) on the same edge, unless `evt_pulse[10]` pulses in that cycle too.
- R6: `status_word[16]` (normal summary) is 1 exactly when any of status bits 0, 2 or 6 is 1.
- R7: `status_word[15]` (abnormal summary) is 1 exactly when any of status bits 1, 3, 5, 7, 8, 9, 10, 11 or 13 is 1. Bits 12 and 14 feed neither summary.
- R8: A pulse on `evt_pulse[13]` captures `bus_err_code` into `status_word[25:23]`. The field then holds that value until the next bus error, and status writes do not change it.
- R9: `status_word` bit 4, bits 22:17 and bits 31:26 always read 0. Writes and `evt_pulse[4]` have no effect on them, and the summary bits cannot be written.
- R10: `irq` is 1 exactly when `status_word[16:0] & irq_mask` is nonzero.
- R11: `rx_state_code` equals `rx_state_in` delayed by one clock. The meaningful codes are 100 (descriptor closed by releasing ownership), 101 (descriptor closed with a status write-back), 110 (suspended, no buffer) and 111 (frame being purged, no buffer).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | 15 | One-cycle event pulses, one per status bit position |
| bus_err_code | input | 3 | Bus error type, sampled when bit 13 pulses |
| rx_state_in | input | 3 | Receive process state code |
| wr_en | input | 1 | Status write strobe |
| wr_data | input | 32 | Write-one-to-clear data |
| irq_mask | input | 17 | Enable mask over status bits 16:0 |
| status_word | output | 32 | Sticky status, summaries and bus error type |
| irq | output | 1 | Interrupt request |
| rx_state_code | output | 3 | Registered receive process state |

## Verification
The bench builds the block with its default widths: a 3-bit error type and a 3-bit receive state. With these widths every error code and every receive state code can be driven exhaustively. A behavioural model tracks all fifteen event positions, including the unused bit 4. This covers the collisions between events and clears, the tx-done versus tx-early ordering, and a mask that exposes only one summary bit.

// File: rtl/irqst_pkg.sv
package irqst_pkg;
    localparam int EVT_W   = 15;
    localparam int STAT_W  = 32;
    localparam int IRQ_W   = 17;
    localparam int ERR_W   = 3;
    localparam int RXST_W  = 3;

    localparam int B_TXDONE = 0;
    localparam int B_RSV4   = 4;
    localparam int B_BUSERR = 13;
    localparam int B_TXEARLY = 10;
    localparam int B_ABN    = 15;
    localparam int B_NRM    = 16;
    localparam int ERR_LO   = 23;

    // bits 0,2,6
    localparam logic [EVT_W-1:0] NRM_SET  = 15'h0045;
    // bits 1,3,5,7,8,9,10,11,13
    localparam logic [EVT_W-1:0] ABN_SET  = 15'h2FAA;
    // every position except 4
    localparam logic [EVT_W-1:0] LIVE_SET = 15'h7FEF;

    typedef struct packed {
        logic nrm;
        logic abn;
    } summ_t;

    function automatic summ_t summarise(input logic [EVT_W-1:0] st);
        summ_t s;
        s.nrm = |(st & NRM_SET);
        s.abn = |(st & ABN_SET);
        return s;
    endfunction
endpackage

// File: rtl/irqst_flag.sv
module irqst_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_ev,
    input  logic clr_wr,
    input  logic auto_clr,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)                   q <= 1'b0;
        else if (set_ev)           q <= 1'b1;
        else if (clr_wr | auto_clr) q <= 1'b0;
    end

    // R2 R4
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        set_ev |=> q);
    // R3
    clr_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && !set_ev) |=> !q);
    // R3
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (q && !set_ev && !clr_wr && !auto_clr) |=> q);
endmodule

// File: rtl/irqst_errcap.sv
module irqst_errcap #(
    parameter int ERR_W = irqst_pkg::ERR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap,
    input  logic [ERR_W-1:0] code_in,
    output logic [ERR_W-1:0] code_q
);
    always_ff @(posedge clk) begin
        if (rst)      code_q <= '0;
        else if (cap) code_q <= code_in;
    end

    // R8
    cap_chk: assert property (@(posedge clk) disable iff (rst)
        cap |=> code_q == $past(code_in));
    // R8
    keep_chk: assert property (@(posedge clk) disable iff (rst)
        !cap |=> $stable(code_q));
endmodule

// File: rtl/irqst_summary.sv
module irqst_summary
    import irqst_pkg::*;
(
    input  logic [EVT_W-1:0] sticky,
    input  logic [IRQ_W-1:0] mask,
    output summ_t            summ,
    output logic             irq
);
    always_comb begin
        summ = summarise(sticky);
        irq  = |({summ.nrm, summ.abn, sticky} & mask);
    end
endmodule

// File: rtl/nic_irq_status.sv
module nic_irq_status
    import irqst_pkg::*;
#(
    parameter int ERR_BITS = irqst_pkg::ERR_W,
    parameter int RX_BITS  = irqst_pkg::RXST_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [EVT_W-1:0]    evt_pulse,
    input  logic [ERR_BITS-1:0] bus_err_code,
    input  logic [RX_BITS-1:0]  rx_state_in,
    input  logic                wr_en,
    input  logic [STAT_W-1:0]   wr_data,
    input  logic [IRQ_W-1:0]    irq_mask,
    output logic [STAT_W-1:0]   status_word,
    output logic                irq,
    output logic [RX_BITS-1:0]  rx_state_code
);
    logic [EVT_W-1:0]    sticky;
    logic [ERR_BITS-1:0] err_q;
    summ_t               summ;

    for (genvar i = 0; i < EVT_W; i++) begin : g_bit
        if (LIVE_SET[i]) begin : g_live
            irqst_flag u_flag (
                .clk      (clk),
                .rst      (rst),
                .set_ev   (evt_pulse[i]),
                .clr_wr   (wr_en & wr_data[i]),
                .auto_clr ((i == B_TXEARLY) ? evt_pulse[B_TXDONE] : 1'b0),
                .q        (sticky[i])
            );
        end else begin : g_hole
            assign sticky[i] = 1'b0;
        end
    end

    irqst_errcap #(.ERR_W(ERR_BITS)) u_err (
        .clk     (clk),
        .rst     (rst),
        .cap     (evt_pulse[B_BUSERR]),
        .code_in (bus_err_code),
        .code_q  (err_q)
    );

    irqst_summary u_sum (
        .sticky (sticky),
        .mask   (irq_mask),
        .summ   (summ),
        .irq    (irq)
    );

    always_ff @(posedge clk) begin
        if (rst) rx_state_code <= '0;
        else     rx_state_code <= rx_state_in;
    end

    always_comb begin
        status_word                   = '0;
        status_word[EVT_W-1:0]        = sticky;
        status_word[B_ABN]            = summ.abn;
        status_word[B_NRM]            = summ.nrm;
        status_word[ERR_LO +: ERR_BITS] = err_q;
    end

    logic unused_bits;
    assign unused_bits = ^{evt_pulse[B_RSV4], wr_data[STAT_W-1:EVT_W]};

    // R5
    early_autoclr_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_pulse[B_TXDONE] && !evt_pulse[B_TXEARLY]) |=> !status_word[B_TXEARLY]);
    // R6
    nrm_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(status_word[B_NRM]) |-> $past(|(evt_pulse & NRM_SET)));
    // R7
    abn_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(status_word[B_ABN]) |-> $past(|(evt_pulse & ABN_SET)));
    // R11
    rx_delay_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> rx_state_code == $past(rx_state_in));
endmodule

// File: tb/sim_nic_irq_status.sv
module sim_nic_irq_status;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [14:0] evt_pulse = '0;
    logic [2:0]  bus_err_code = '0;
    logic [2:0]  rx_state_in = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [16:0] irq_mask = '0;
    logic [31:0] status_word;
    logic        irq;
    logic [2:0]  rx_state_code;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit done    = 0;

    // behavioural reference state
    bit [14:0] m_st  = '0;
    bit [2:0]  m_err = '0;
    bit [2:0]  m_rx  = '0;
    int abn_list[9] = '{1, 3, 5, 7, 8, 9, 10, 11, 13};

    always #10 clk = ~clk;

    nic_irq_status u0 (
        .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .bus_err_code(bus_err_code),
        .rx_state_in(rx_state_in), .wr_en(wr_en), .wr_data(wr_data),
        .irq_mask(irq_mask), .status_word(status_word), .irq(irq),
        .rx_state_code(rx_state_code)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired at cycle %0d", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    function automatic bit [31:0] exp_word();
        bit [31:0] w = '0;
        bit a = 0;
        for (int i = 0; i < 15; i++) if (i != 4) w[i] = m_st[i];
        foreach (abn_list[k]) a = a | m_st[abn_list[k]];
        w[15] = a;
        w[16] = m_st[0] | m_st[2] | m_st[6];
        w[25:23] = m_err;
        return w;
    endfunction

    task automatic check_all(input string tag);
        bit [31:0] ew = exp_word();
        bit ei = |(ew[16:0] & irq_mask);
        n_tests++;
        if (status_word !== ew) begin
            n_fail++;
            $display("FAIL %s status_word actual=%h expected=%h", tag, status_word, ew);
        end
        n_tests++;
        if (irq !== ei) begin
            n_fail++;
            $display("FAIL %s irq actual=%b expected=%b", tag, irq, ei);
        end
        n_tests++;
        if (rx_state_code !== m_rx) begin
            n_fail++;
            $display("FAIL %s rx_state_code actual=%b expected=%b", tag, rx_state_code, m_rx);
        end
    endtask

    // called at a negedge: drive, advance model, wait one cycle, compare
    task automatic step(input string tag, input bit [14:0] ev, input bit we,
                        input bit [31:0] wd, input bit [16:0] mk,
                        input bit [2:0] ec, input bit [2:0] rs);
        evt_pulse = ev; wr_en = we; wr_data = wd; irq_mask = mk;
        bus_err_code = ec; rx_state_in = rs;
        for (int i = 0; i < 15; i++) begin
            if (i == 4) continue;
            if (ev[i]) m_st[i] = 1'b1;
            else if (we && wd[i]) m_st[i] = 1'b0;
            else if (i == 10 && ev[0]) m_st[i] = 1'b0;
        end
        if (ev[13]) m_err = ec;
        m_rx = rs;
        @(posedge clk);
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic idle(input string tag, input bit [16:0] mk);
        step(tag, '0, 1'b0, '0, mk, 3'd0, m_rx);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_all("R1 in reset");
        rst = 1'b0;
        @(negedge clk);
        check_all("R1 after reset");

        // R2 each position, R9 includes position 4
        for (int i = 0; i < 15; i++) begin
            step("R2 set", 15'(1 << i), 1'b0, '0, '1, 3'd2, 3'd0);
            idle("R2 hold", '1);
            step("R9 clear all", '0, 1'b1, '1, '1, 3'd0, 3'd0);
        end

        // R3 write one clears, write zero keeps
        step("R3 setup", 15'h1041, 1'b0, '0, '1, 3'd0, 3'd0);
        step("R3 w1c", '0, 1'b1, 32'h0000_0040, '1, 3'd0, 3'd0);
        step("R3 w0 keep", '0, 1'b1, 32'h0, '1, 3'd0, 3'd0);

        // R4 event beats clear
        step("R4 collide", 15'h0080, 1'b1, 32'h0000_0080, '1, 3'd0, 3'd0);
        step("R4 clear", '0, 1'b1, '1, '1, 3'd0, 3'd0);

        // R5 tx done clears tx early
        step("R5 early", 15'h0400, 1'b0, '0, '1, 3'd0, 3'd0);
        step("R5 done clears", 15'h0001, 1'b0, '0, '1, 3'd0, 3'd0);
        step("R5 both", 15'h0401, 1'b0, '0, '1, 3'd0, 3'd0);
        step("R5 clear", '0, 1'b1, '1, '1, 3'd0, 3'd0);

        // R6 R7 grouping
        step("R7 link+erx none", 15'h5000, 1'b0, '0, '1, 3'd0, 3'd0);
        step("R6 rx done", 15'h0040, 1'b0, '0, '1, 3'd0, 3'd0);
        step("R7 underrun", 15'h0020, 1'b0, '0, '1, 3'd0, 3'd0);
        step("R9 summaries unwritable", '0, 1'b1, 32'h0001_8000, '1, 3'd0, 3'd0);
        step("R6 clear", '0, 1'b1, '1, '1, 3'd0, 3'd0);

        // R8 bus error type
        step("R8 capture", 15'h2000, 1'b0, '0, '1, 3'd5, 3'd0);
        step("R8 no cap", '0, 1'b0, '0, '1, 3'd2, 3'd0);
        step("R8 write keeps", '0, 1'b1, '1, '1, 3'd7, 3'd0);
        step("R8 recapture", 15'h2000, 1'b0, '0, '1, 3'd3, 3'd0);

        // R10 mask
        step("R10 only nrm", 15'h0001, 1'b0, '0, 17'h10000, 3'd0, 3'd0);
        idle("R10 abn masked", 17'h08000);
        idle("R10 none", 17'h00000);
        idle("R10 bit13", 17'h02000);

        // R11 receive state codes
        for (int c = 0; c < 8; c++)
            step("R11 rx code", '0, 1'b0, '0, '1, 3'd0, 3'(c));

        // mixed traffic against the model
        for (int n = 0; n < 400; n++)
            step("R2 mixed", 15'($urandom) & 15'($urandom), ($urandom % 3) == 0,
                 $urandom, 17'($urandom), 3'($urandom), 3'($urandom));

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule